// File: doc/BRIEF.md
# Slave-Side Arbiter with Default-Master Parking

This block is the grant logic that sits in front of one slave port of a multi-master bus interconnect. Up to sixteen masters raise request lines toward the slave. The block drives a one-hot grant, which selects whose address and data path reaches the slave, and a flag showing that some master is connected. An access begins in a cycle where the granted master is requesting. It ends in the cycle where the access-end input is high, and it may end in the same cycle it begins. The grant changes only at an access boundary. A master therefore keeps the slave for its whole burst.

When the slave has nothing to do, the grant is parked on a default master chosen by a per-port policy. The policy can disconnect the slave, stay on the master that made the last access, or move to a programmed fixed master. A master that is already parked when it requests starts its access at once. Any other master waits one arbitration cycle while the grant is moved to it. When several masters compete at a boundary, a round-robin scan picks the winner, starting just after the master that last began an access.

Top module: `dm_slave_arb`

## Requirements
- R1: The grant is always one-hot or all zero.
- R2: While reset is asserted, the grant is all zero and `connected` is 0.
- R3: Once an access has started, the grant is held unchanged through the cycle in which `acc_end` is 1, whatever other masters request. It can change at the clock edge that ends that cycle, at the earliest.
- R4: If the master granted on an idle slave requests, its access starts in that same cycle. This holds even when other masters also request. The grant does not change at that edge, and no arbitration cycle is added.
- R5: A requesting master that is not granted on an idle slave, or that is pending when an access ends, receives the grant at the next clock edge (one arbitration cycle), provided it wins arbitration.
- R6: When masters request at a boundary, the winner is the first requester found by scanning upward from the index after the master that last started an access, wrapping at the master count. The requesting master whose access is just ending takes part in this scan.
- R7: With `cfg_type` = 0 (no default), a boundary with no request clears the grant at the next edge.
- R8: With `cfg_type` = 1 (last master), a boundary with no request parks the grant on the master that last started an access. That is master 0 if no access has started since reset.
- R9: With `cfg_type` = 2 (fixed), a boundary with no request parks the grant on master `cfg_fixed`.
- R10: `cfg_type` = 3 behaves like 0. So does `cfg_type` = 2 when `cfg_fixed` is at or above the master count.
- R11: `connected` is 1 exactly when some grant bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | Request line of each master |
| acc_end | input | 1 | The current access ends in this cycle |
| cfg_type | input | 2 | Parking policy: 0 none, 1 last master, 2 fixed, 3 treated as none |
| cfg_fixed | input | 4 | Index of the fixed parked master |
| gnt | output | NUM_MASTERS | One-hot grant, registered |
| connected | output | 1 | Some master is granted |

## Verification
Every result is a registered output. It reflects the inputs sampled at one clock edge and is valid right after that edge, so the bench drives inputs at the falling edge and samples one time unit after the rising edge. A parked master's access shows up as a grant that stays put across its first edge (R4). A non-parked winner is granted after exactly one edge (R5). A parking decision shows up one edge after the boundary cycle. A behavioural model in the bench, built on integer indices, advances once per rising edge from the same sampled inputs. The bench compares the model with the grant and `connected` after every edge, using directed sequences and long random runs under each policy.

// File: rtl/dm_arb_pkg.sv
package dm_arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;

  localparam int FIXED_W = 4;
endpackage

// File: rtl/dm_rr_pick.sv
module dm_rr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last_idx,
  output logic          any,
  output logic [IW-1:0] win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_idx) + k) % N;
      if (!any && req[idx]) begin
        any = 1'b1;
        win = idx[IW-1:0];
      end
    end
  end

  always_comb begin
    if (any) begin
      AST_RR_WIN_REQ: assert (req[win]); // R6
    end
  end
endmodule

// File: rtl/dm_park_sel.sv
module dm_park_sel
  import dm_arb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  park_mode_e           mode,
  input  logic [FIXED_W-1:0]   fixed_idx,
  input  logic [IW-1:0]        last_idx,
  output logic                 park_vld,
  output logic [IW-1:0]        park_idx
);
  logic fixed_ok;

  assign fixed_ok = (int'(fixed_idx) < N);

  always_comb begin
    park_vld = 1'b0;
    park_idx = '0;
    case (mode)
      PARK_LAST: begin
        park_vld = 1'b1;
        park_idx = last_idx;
      end
      PARK_FIXED: begin
        if (fixed_ok) begin
          park_vld = 1'b1;
          park_idx = IW'(fixed_idx);
        end
      end
      default: begin
        park_vld = 1'b0;
        park_idx = '0;
      end
    endcase
  end
endmodule

// File: rtl/dm_slave_arb.sv
module dm_slave_arb
  import dm_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   acc_end,
  input  logic [1:0]             cfg_type,
  input  logic [3:0]             cfg_fixed,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   connected
);
  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [NUM_MASTERS-1:0] ONE = {{(NUM_MASTERS-1){1'b0}}, 1'b1};

  logic [NUM_MASTERS-1:0] gnt_q, gnt_d;
  logic                   busy_q, busy_d;
  logic [IW-1:0]          last_q, last_d;
  logic                   gnt_en, last_en;

  logic [IW-1:0]          owner;
  logic                   hit, start, boundary;
  logic                   rr_any;
  logic [IW-1:0]          rr_win;
  logic                   park_vld;
  logic [IW-1:0]          park_idx;

  // index of the currently granted master
  always_comb begin
    owner = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (gnt_q[i]) owner = IW'(i);
    end
  end

  assign hit      = |(gnt_q & req);
  assign start    = !busy_q && hit;
  assign boundary = busy_q ? acc_end : (hit ? acc_end : 1'b1);

  assign last_en  = start;
  assign last_d   = start ? owner : last_q;
  assign gnt_en   = boundary;

  dm_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_rr (
    .req      (req),
    .last_idx (last_d),
    .any      (rr_any),
    .win      (rr_win)
  );

  dm_park_sel #(.N(NUM_MASTERS), .IW(IW)) u_park (
    .mode      (park_mode_e'(cfg_type)),
    .fixed_idx (cfg_fixed),
    .last_idx  (last_d),
    .park_vld  (park_vld),
    .park_idx  (park_idx)
  );

  // next-state
  always_comb begin
    busy_d = !boundary;
    gnt_d  = gnt_q;
    if (boundary) begin
      if (rr_any)        gnt_d = ONE << rr_win;
      else if (park_vld) gnt_d = ONE << park_idx;
      else               gnt_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (gnt_en)  gnt_q  <= gnt_d;
      if (last_en) last_q <= last_d;
    end
  end

  assign gnt       = gnt_q;
  assign connected = |gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R1

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !acc_end) |=> $stable(gnt_q)); // R3

  AST_PARK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hit && !acc_end) |=> ($stable(gnt_q) && busy_q)); // R4

  AST_NODEF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !(|req) && !park_vld) |=> (gnt_q == '0)); // R7

  AST_CONN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    connected == (gnt != '0)); // R11
endmodule

// File: tb/dm_slave_arb_tb.sv
module dm_slave_arb_tb;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         acc_end;
  logic [1:0]   cfg_type;
  logic [3:0]   cfg_fixed;
  logic [N-1:0] gnt;
  logic         connected;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  int m_gnt, m_busy, m_last;

  always #2 clk = ~clk;

  dm_slave_arb #(.NUM_MASTERS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .acc_end(acc_end),
    .cfg_type(cfg_type), .cfg_fixed(cfg_fixed),
    .gnt(gnt), .connected(connected)
  );

  task automatic chk(input string r, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", r, got, exp, $time);
    end
  endtask

  function automatic int model_vec();
    return (m_gnt < 0) ? 0 : (1 << m_gnt);
  endfunction

  // behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gnt = -1; m_busy = 0; m_last = 0;
    end else begin
      bit h, bnd;
      int w;
      h = (m_gnt >= 0) && req[m_gnt];
      if (m_busy != 0) bnd = acc_end;
      else if (h)      bnd = acc_end;
      else             bnd = 1'b1;
      if (m_busy == 0 && h) m_last = m_gnt;
      if (bnd) begin
        w = -1;
        for (int k = 1; k <= N; k++) begin
          if (w < 0 && req[(m_last + k) % N]) w = (m_last + k) % N;
        end
        if (w >= 0) m_gnt = w;
        else if (cfg_type == 2'd1) m_gnt = m_last;
        else if (cfg_type == 2'd2 && cfg_fixed < N) m_gnt = int'(cfg_fixed);
        else m_gnt = -1;
        m_busy = 0;
      end else begin
        m_busy = 1;
      end
    end
    #1;
    if (rst_n && !done) begin
      chk(tag, int'(gnt), model_vec());
      chk("R1", int'($onehot0(gnt)), 1);
      chk("R11", int'(connected), int'(gnt != '0));
    end
  end

  task automatic step(input logic [N-1:0] r, input bit e);
    @(negedge clk);
    req = r; acc_end = e;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; acc_end = 1'b0;
    cfg_type = 2'd1; cfg_fixed = 4'd0;
    repeat (3) @(negedge clk);
    chk("R2", int'(gnt), 0);
    chk("R2", int'(connected), 0);
    rst_n = 1'b1;

    // last-master policy, parks on master 0 after reset
    tag = "R8";
    step(6'b000000, 0); chk("R8", int'(gnt), 1);
    // parked master 0 requests together with master 2: zero wait
    tag = "R4";
    step(6'b000101, 0); chk("R4", int'(gnt), 1);
    tag = "R3";
    repeat (3) begin step(6'b000101, 0); chk("R3", int'(gnt), 1); end
    // end of burst, master 2 pending: round-robin after 0 gives 2
    tag = "R6";
    step(6'b000101, 1); chk("R6", int'(gnt), 4);
    step(6'b000100, 0); chk("R3", int'(gnt), 4);
    tag = "R8";
    step(6'b000000, 1); chk("R8", int'(gnt), 4);
    step(6'b000000, 0); chk("R8", int'(gnt), 4);

    // no-default policy
    cfg_type = 2'd0; tag = "R7";
    step(6'b000000, 0); chk("R7", int'(gnt), 0); chk("R11", int'(connected), 0);
    tag = "R5";
    step(6'b000010, 0); chk("R5", int'(gnt), 2);
    step(6'b000010, 1); chk("R6", int'(gnt), 2);
    tag = "R7";
    step(6'b000000, 0); chk("R7", int'(gnt), 0);

    // fixed policy on master 3
    cfg_type = 2'd2; cfg_fixed = 4'd3; tag = "R9";
    step(6'b000000, 0); chk("R9", int'(gnt), 8);
    tag = "R4";
    step(6'b001000, 0); chk("R4", int'(gnt), 8);
    tag = "R6";
    step(6'b001001, 1); chk("R6", int'(gnt), 1);
    step(6'b000001, 1); chk("R6", int'(gnt), 1);

    // out-of-range fixed index and reserved type
    cfg_fixed = 4'd7; tag = "R10";
    step(6'b000000, 0); chk("R10", int'(gnt), 0);
    cfg_type = 2'd2; cfg_fixed = 4'd5;
    step(6'b000000, 0); chk("R9", int'(gnt), 32);
    cfg_type = 2'd3;
    step(6'b000000, 0); chk("R10", int'(gnt), 0);

    // random traffic under each policy
    for (int p = 0; p < 8; p++) begin
      cfg_type  = 2'(p % 4);
      cfg_fixed = 4'((p * 5) % 9);
      tag = (p % 4 == 0) ? "R7" : (p % 4 == 1) ? "R8" : (p % 4 == 2) ? "R9" : "R10";
      for (int c = 0; c < 2500; c++) begin
        logic [N-1:0] r;
        r = N'($urandom) & N'($urandom);
        step(r, ($urandom % 3) == 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule